// File: doc/BRIEF.md
# Card Command Sequencer with Response Capture

This block takes a host command word and argument, decodes the index, response kind, data-present flag and transfer direction, and hands the command to a card-side agent. It then waits for that agent's response bytes and length. It checks the length against the response kind and stores the bytes in a bank of four 32-bit response words. It raises single-cycle events for command done, response timeout and transfer done. It updates a card-error level from the card status bits, filtered per command index and by a software enable mask.

The host side is valid/ready. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while nothing is in flight, so the host must hold its word and argument until acceptance. Toward the card, `card_req_valid` stays high with a stable index and argument until `card_req_ready` is seen. The card agent then presents its response with `card_rsp_valid`. The response is taken only on an edge where `card_rsp_ready` is also high, and `card_rsp_ready` is high only while a response is awaited. The configuration pins (`init_mode`, `err_enable`, `card_is_mmc`) are plain levels, sampled when the response is taken, or on acceptance for the init shortcut.

Byte 0 of `card_rsp_data` sits in bits 127..120 and byte 15 in bits 7..0. In `rsp_out`, word k occupies bits 32k+31..32k.

Top module: `cmd_rsp_engine`

## Requirements
- R1: `cmd_ready` is high exactly when no command is in flight. After acceptance, `card_req_valid` rises in the next cycle and presents index = word bits 29..24 and the argument. It holds both stable until `card_req_ready` is high at an edge, then drops.
- R2: `cmd_busy` rises in the cycle after a command is accepted for the card. It stays high, with no event, until the response is taken. It falls in the same cycle that `ev_cmd_done` or `ev_timeout` appears.
- R3: With `init_mode` high, an accepted command with index 0 gives `ev_cmd_done` in the next cycle. It makes no card request, sets no busy flag and starts no data phase, and it leaves the response words and `card_err` unchanged.
- R4: Response kind is word bits 17..16: 0 none, 1 long, 2 short, 3 short with busy. Long needs length ≥ 16 and both short kinds need length ≥ 4, otherwise `ev_timeout` pulses instead of `ev_cmd_done`. Kind 0 always gives `ev_cmd_done`.
- R5: A long response that is long enough stores bytes 0..3 big-endian in word 3, bytes 4..7 in word 2, bytes 8..11 in word 1 and bytes 12..15 in word 0.
- R6: A short response that is long enough stores bytes 0..3 big-endian in word 0 and leaves words 1..3 unchanged. A timeout or kind 0 changes no word.
- R7: For short kinds, the status word (word 0 of the response) is masked by index. Index 3 keeps bits 11..9. Index 41, and index 8 when `card_is_mmc` is low, keep nothing. Every other index keeps bits 31..26, 24..19, 16 and 15.
- R8: At each card response, `card_err` becomes 1 if the masked status ANDed with `err_enable` is nonzero and 0 otherwise. When it becomes 1 on a command with data present, `data_abort` pulses.
- R9: A command of kind 3 with no data present, no timeout and no card error pulses `ev_xfer_done` together with its completion event.
- R10: Index 12 or 52 pulses `xfer_stop` and `ev_xfer_done` together with its completion event, whatever its kind.
- R11: When a command with data present (bit 21) is accepted for the card, `data_start` pulses in the next cycle, and `data_dir_read` takes bit 4 (1 = read) and holds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command offered |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_word | input | 32 | Command word (index, kind, data present, direction) |
| cmd_arg | input | 32 | Command argument |
| init_mode | input | 1 | Initialization mode level |
| err_enable | input | 32 | Card-status error enable mask |
| card_is_mmc | input | 1 | Attached card is MMC type |
| card_req_valid | output | 1 | Command offered to card agent |
| card_req_ready | input | 1 | Card agent takes the command |
| card_req_index | output | 6 | Command index toward card |
| card_req_arg | output | 32 | Argument toward card |
| card_rsp_valid | input | 1 | Card response present |
| card_rsp_ready | output | 1 | Engine awaits a response |
| card_rsp_len | input | 5 | Response length in bytes (0..16) |
| card_rsp_data | input | 128 | Response bytes, byte 0 in the top bits |
| rsp_out | output | 128 | Four captured response words |
| cmd_busy | output | 1 | Command in flight |
| ev_cmd_done | output | 1 | Command complete pulse |
| ev_timeout | output | 1 | Response timeout pulse |
| ev_xfer_done | output | 1 | Transfer complete pulse |
| card_err | output | 1 | Card-status error level |
| data_start | output | 1 | Data phase start pulse |
| data_dir_read | output | 1 | Data phase direction, 1 = read |
| data_abort | output | 1 | Data phase cancelled pulse |
| xfer_stop | output | 1 | Stop command: end transfer, drop ready flags and DMA requests |

## Verification
The sequencer state shows on every port. If it is stuck or skips a step, `cmd_ready`, `card_req_valid`, `card_rsp_ready` or `cmd_busy` is wrong in the very next cycle after acceptance or handshake. A wrong latched field shows in `card_req_index`, `data_start` or `data_dir_read` one cycle after acceptance. A wrong length check, mask choice or byte mapping appears in the completion cycle: `ev_cmd_done` and `ev_timeout` swap, `card_err` takes the wrong level, or `rsp_out` differs in the touched or untouched words. Because `card_err` and the response words persist, a stale value also carries into the checks of the next command.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 6;

  // Fixed field positions within the command word
  localparam int FLD_IDX_LO  = 24;
  localparam int FLD_KIND_LO = 16;
  localparam int FLD_DP      = 21;
  localparam int FLD_DIR     = 4;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_LONG       = 2'd1,
    RSP_SHORT      = 2'd2,
    RSP_SHORT_BUSY = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [IDX_W-1:0] index;
    rsp_kind_e        kind;
    logic             data_present;
    logic             dir_read;
  } cmd_fields_t;

  localparam logic [IDX_W-1:0] IDX_RESET   = 6'd0;
  localparam logic [IDX_W-1:0] IDX_RCA     = 6'd3;
  localparam logic [IDX_W-1:0] IDX_IFCOND  = 6'd8;
  localparam logic [IDX_W-1:0] IDX_STOP    = 6'd12;
  localparam logic [IDX_W-1:0] IDX_OPCOND  = 6'd41;
  localparam logic [IDX_W-1:0] IDX_IO_DIR  = 6'd52;

  localparam logic [WORD_W-1:0] STD_ERR_MASK = 32'hFDF9_8000;
  localparam logic [WORD_W-1:0] RCA_ERR_MASK = 32'h0000_0E00;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmdrsp_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_fields_t       fields,
  output logic              is_stop
);
  logic unused_word_bits;

  always_comb begin
    fields.index        = word[FLD_IDX_LO +: IDX_W];
    fields.kind         = rsp_kind_e'(word[FLD_KIND_LO +: 2]);
    fields.data_present = word[FLD_DP];
    fields.dir_read     = word[FLD_DIR];
    is_stop = (fields.index == IDX_STOP) || (fields.index == IDX_IO_DIR);
  end

  assign unused_word_bits = ^word;
endmodule

// File: rtl/status_filter.sv
module status_filter
  import cmdrsp_pkg::*;
#(
  parameter int RSP_BYTES = 16,
  parameter int LEN_W     = 5
) (
  input  logic [IDX_W-1:0]  index,
  input  rsp_kind_e         kind,
  input  logic              card_is_mmc,
  input  logic [LEN_W-1:0]  rsp_len,
  input  logic [WORD_W-1:0] status_word,
  input  logic [WORD_W-1:0] err_enable,
  output logic              too_short,
  output logic              err_hit
);
  localparam int SHORT_BYTES = WORD_W / 8;

  logic              long_ok;
  logic              short_ok;
  logic [WORD_W-1:0] sel_mask;

  assign long_ok  = rsp_len >= LEN_W'(RSP_BYTES);
  assign short_ok = rsp_len >= LEN_W'(SHORT_BYTES);

  always_comb begin
    too_short = 1'b0;
    sel_mask  = '0;
    unique case (kind)
      RSP_LONG: too_short = !long_ok;
      RSP_SHORT, RSP_SHORT_BUSY: begin
        too_short = !short_ok;
        if (short_ok) begin
          if (index == IDX_RCA)
            sel_mask = RCA_ERR_MASK;
          else if (index == IDX_OPCOND)
            sel_mask = '0;
          else if (index == IDX_IFCOND && !card_is_mmc)
            sel_mask = '0;
          else
            sel_mask = STD_ERR_MASK;
        end
      end
      default: ;
    endcase
    err_hit = |(status_word & sel_mask & err_enable);
  end
endmodule

// File: rtl/rsp_capture.sv
module rsp_capture
  import cmdrsp_pkg::*;
#(
  parameter int RSP_WORDS = 4,
  localparam int RSP_W    = RSP_WORDS * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  rsp_kind_e        kind,
  input  logic             too_short,
  input  logic [RSP_W-1:0] rsp_data,
  output logic [RSP_W-1:0] rsp_words
);
  logic take;
  assign take = capture && !too_short;

  for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_words[k*WORD_W +: WORD_W] <= '0;
      end else if (take) begin
        if (kind == RSP_LONG) begin
          rsp_words[k*WORD_W +: WORD_W] <= rsp_data[k*WORD_W +: WORD_W];
        end else if ((k == 0) && (kind == RSP_SHORT || kind == RSP_SHORT_BUSY)) begin
          rsp_words[k*WORD_W +: WORD_W] <= rsp_data[RSP_W-1 -: WORD_W];
        end
      end
    end
  end
endmodule

// File: rtl/cmd_rsp_engine.sv
module cmd_rsp_engine
  import cmdrsp_pkg::*;
#(
  parameter int RSP_WORDS = 4,
  localparam int RSP_W     = RSP_WORDS * WORD_W,
  localparam int RSP_BYTES = RSP_W / 8,
  localparam int LEN_W     = $clog2(RSP_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [WORD_W-1:0] cmd_arg,
  input  logic              init_mode,
  input  logic [WORD_W-1:0] err_enable,
  input  logic              card_is_mmc,
  output logic              card_req_valid,
  input  logic              card_req_ready,
  output logic [IDX_W-1:0]  card_req_index,
  output logic [WORD_W-1:0] card_req_arg,
  input  logic              card_rsp_valid,
  output logic              card_rsp_ready,
  input  logic [LEN_W-1:0]  card_rsp_len,
  input  logic [RSP_W-1:0]  card_rsp_data,
  output logic [RSP_W-1:0]  rsp_out,
  output logic              cmd_busy,
  output logic              ev_cmd_done,
  output logic              ev_timeout,
  output logic              ev_xfer_done,
  output logic              card_err,
  output logic              data_start,
  output logic              data_dir_read,
  output logic              data_abort,
  output logic              xfer_stop
);
  seq_state_e        state_q;
  cmd_fields_t       dec;
  logic              dec_stop;
  logic [IDX_W-1:0]  index_q;
  rsp_kind_e         kind_q;
  logic              dp_q;
  logic              stop_q;
  logic [WORD_W-1:0] arg_q;
  logic              too_short;
  logic              err_hit;
  logic              accept;
  logic              rsp_take;
  logic              init_shortcut;

  cmd_decode u_decode (
    .word    (cmd_word),
    .fields  (dec),
    .is_stop (dec_stop)
  );

  status_filter #(.RSP_BYTES(RSP_BYTES), .LEN_W(LEN_W)) u_filter (
    .index       (index_q),
    .kind        (kind_q),
    .card_is_mmc (card_is_mmc),
    .rsp_len     (card_rsp_len),
    .status_word (card_rsp_data[RSP_W-1 -: WORD_W]),
    .err_enable  (err_enable),
    .too_short   (too_short),
    .err_hit     (err_hit)
  );

  rsp_capture #(.RSP_WORDS(RSP_WORDS)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rsp_take),
    .kind      (kind_q),
    .too_short (too_short),
    .rsp_data  (card_rsp_data),
    .rsp_words (rsp_out)
  );

  assign cmd_ready      = (state_q == ST_IDLE);
  assign cmd_busy       = (state_q != ST_IDLE);
  assign card_req_valid = (state_q == ST_ISSUE);
  assign card_rsp_ready = (state_q == ST_WAIT);
  assign card_req_index = index_q;
  assign card_req_arg   = arg_q;
  assign accept         = cmd_valid && cmd_ready;
  assign rsp_take       = card_rsp_valid && card_rsp_ready;
  assign init_shortcut  = init_mode && (dec.index == IDX_RESET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      index_q       <= '0;
      kind_q        <= RSP_NONE;
      dp_q          <= 1'b0;
      stop_q        <= 1'b0;
      arg_q         <= '0;
      ev_cmd_done   <= 1'b0;
      ev_timeout    <= 1'b0;
      ev_xfer_done  <= 1'b0;
      card_err      <= 1'b0;
      data_start    <= 1'b0;
      data_dir_read <= 1'b0;
      data_abort    <= 1'b0;
      xfer_stop     <= 1'b0;
    end else begin
      ev_cmd_done  <= 1'b0;
      ev_timeout   <= 1'b0;
      ev_xfer_done <= 1'b0;
      data_start   <= 1'b0;
      data_abort   <= 1'b0;
      xfer_stop    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (init_shortcut) begin
              ev_cmd_done <= 1'b1;
            end else begin
              index_q    <= dec.index;
              kind_q     <= dec.kind;
              dp_q       <= dec.data_present;
              stop_q     <= dec_stop;
              arg_q      <= cmd_arg;
              state_q    <= ST_ISSUE;
              data_start <= dec.data_present;
              if (dec.data_present) data_dir_read <= dec.dir_read;
            end
          end
        end
        ST_ISSUE: begin
          if (card_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_take) begin
            state_q      <= ST_IDLE;
            ev_cmd_done  <= !too_short;
            ev_timeout   <= too_short;
            card_err     <= err_hit;
            data_abort   <= err_hit && dp_q;
            xfer_stop    <= stop_q;
            ev_xfer_done <= stop_q ||
                            (!err_hit && !too_short && !dp_q && kind_q == RSP_SHORT_BUSY);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_rsp_engine_checker.sv
module cmd_rsp_engine_checker #(
  parameter int RSP_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             card_req_valid,
  input logic             card_req_ready,
  input logic [5:0]       card_req_index,
  input logic [31:0]      card_req_arg,
  input logic [RSP_W-1:0] rsp_out,
  input logic             cmd_busy,
  input logic             ev_cmd_done,
  input logic             ev_timeout,
  input logic             ev_xfer_done,
  input logic             card_err,
  input logic             data_start,
  input logic             data_abort,
  input logic             xfer_stop
);
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    card_req_valid && !card_req_ready |=>
      card_req_valid && $stable(card_req_index) && $stable(card_req_arg));

  a_r1_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy) |-> !cmd_ready);

  a_r2_fall_with_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_busy) |-> (ev_cmd_done || ev_timeout));

  a_r2_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    card_req_valid |-> cmd_busy);

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_cmd_done && ev_timeout));

  a_r6_words_move_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_out) |-> ev_cmd_done);

  a_r8_abort_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    data_abort |-> card_err);

  a_r10_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stop |-> ev_xfer_done);

  a_r11_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> $past(cmd_valid && cmd_ready));
endmodule

bind cmd_rsp_engine cmd_rsp_engine_checker #(.RSP_W(RSP_W)) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_ready      (cmd_ready),
  .card_req_valid (card_req_valid),
  .card_req_ready (card_req_ready),
  .card_req_index (card_req_index),
  .card_req_arg   (card_req_arg),
  .rsp_out        (rsp_out),
  .cmd_busy       (cmd_busy),
  .ev_cmd_done    (ev_cmd_done),
  .ev_timeout     (ev_timeout),
  .ev_xfer_done   (ev_xfer_done),
  .card_err       (card_err),
  .data_start     (data_start),
  .data_abort     (data_abort),
  .xfer_stop      (xfer_stop)
);

// File: tb/cmd_rsp_engine_tb.sv
module cmd_rsp_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [31:0]  cmd_word = '0;
  logic [31:0]  cmd_arg = '0;
  logic         init_mode = 1'b0;
  logic [31:0]  err_enable = '0;
  logic         card_is_mmc = 1'b0;
  logic         card_req_valid;
  logic         card_req_ready = 1'b0;
  logic [5:0]   card_req_index;
  logic [31:0]  card_req_arg;
  logic         card_rsp_valid = 1'b0;
  logic         card_rsp_ready;
  logic [4:0]   card_rsp_len = '0;
  logic [127:0] card_rsp_data = '0;
  logic [127:0] rsp_out;
  logic         cmd_busy, ev_cmd_done, ev_timeout, ev_xfer_done, card_err;
  logic         data_start, data_dir_read, data_abort, xfer_stop;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [127:0] exp_rsp = '0;
  logic         exp_err = 1'b0;
  logic         exp_dir = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_rsp_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_arg(cmd_arg), .init_mode(init_mode),
    .err_enable(err_enable), .card_is_mmc(card_is_mmc),
    .card_req_valid(card_req_valid), .card_req_ready(card_req_ready),
    .card_req_index(card_req_index), .card_req_arg(card_req_arg),
    .card_rsp_valid(card_rsp_valid), .card_rsp_ready(card_rsp_ready),
    .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data),
    .rsp_out(rsp_out), .cmd_busy(cmd_busy), .ev_cmd_done(ev_cmd_done),
    .ev_timeout(ev_timeout), .ev_xfer_done(ev_xfer_done), .card_err(card_err),
    .data_start(data_start), .data_dir_read(data_dir_read),
    .data_abort(data_abort), .xfer_stop(xfer_stop)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input int idx, input int kind, input bit dp, input bit dir);
    logic [31:0] w;
    w = '0;
    w[29:24] = idx[5:0];
    w[17:16] = kind[1:0];
    w[21]    = dp;
    w[4]     = dir;
    return w;
  endfunction

  // Expected status mask per requirement R7
  function automatic logic [31:0] exp_mask(input int idx, input int kind, input bit mmc);
    if (kind < 2) return 32'h0;
    if (idx == 3) return 32'h0000_0E00;
    if (idx == 41) return 32'h0;
    if (idx == 8 && !mmc) return 32'h0;
    return 32'hFDF9_8000;
  endfunction

  task automatic run_cmd(input logic [31:0] w, input logic [31:0] a, input int len,
                         input logic [127:0] data, input int req_wait, input int rsp_wait);
    int  idx, kind;
    bit  dp, dir, fast, to, err, stp, xd;
    idx  = int'(w[29:24]);
    kind = int'(w[17:16]);
    dp   = w[21];
    dir  = w[4];
    fast = init_mode && (idx == 0);
    @(negedge clk);
    check("R1 ready idle", {127'b0, cmd_ready}, 128'd1);
    cmd_valid = 1'b1; cmd_word = w; cmd_arg = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (fast) begin
      check("R3 done", {127'b0, ev_cmd_done}, 128'd1);
      check("R3 no busy", {127'b0, cmd_busy}, 128'd0);
      check("R3 no req", {127'b0, card_req_valid}, 128'd0);
      check("R3 no start", {127'b0, data_start}, 128'd0);
      check("R3 rsp kept", rsp_out, exp_rsp);
      check("R3 err kept", {127'b0, card_err}, {127'b0, exp_err});
      return;
    end
    check("R2 busy", {127'b0, cmd_busy}, 128'd1);
    check("R1 not ready", {127'b0, cmd_ready}, 128'd0);
    check("R11 start", {127'b0, data_start}, {127'b0, dp});
    if (dp) exp_dir = dir;
    check("R11 dir", {127'b0, data_dir_read}, {127'b0, exp_dir});
    check("R1 req valid", {127'b0, card_req_valid}, 128'd1);
    check("R1 index", {122'b0, card_req_index}, 128'(idx));
    check("R1 arg", {96'b0, card_req_arg}, {96'b0, a});
    for (int i = 0; i < req_wait; i++) begin
      @(negedge clk);
      check("R1 hold", {127'b0, card_req_valid}, 128'd1);
    end
    card_req_ready = 1'b1;
    @(negedge clk);
    card_req_ready = 1'b0;
    check("R1 req drop", {127'b0, card_req_valid}, 128'd0);
    for (int i = 0; i < rsp_wait; i++) begin
      @(negedge clk);
      check("R2 busy wait", {126'b0, cmd_busy, ev_cmd_done | ev_timeout}, 128'd2);
    end
    card_rsp_valid = 1'b1; card_rsp_len = 5'(len); card_rsp_data = data;
    @(negedge clk);
    card_rsp_valid = 1'b0;
    to  = (kind == 1 && len < 16) || (kind >= 2 && len < 4);
    err = !to && |(data[127:96] & exp_mask(idx, kind, card_is_mmc) & err_enable);
    stp = (idx == 12) || (idx == 52);
    xd  = stp || (!err && !to && !dp && kind == 3);
    if (!to && kind == 1) exp_rsp = data;
    if (!to && kind >= 2) exp_rsp[31:0] = data[127:96];
    exp_err = err;
    check("R4 done", {127'b0, ev_cmd_done}, {127'b0, !to});
    check("R4 timeout", {127'b0, ev_timeout}, {127'b0, to});
    check("R5/R6 words", rsp_out, exp_rsp);
    check("R7/R8 card_err", {127'b0, card_err}, {127'b0, err});
    check("R8 abort", {127'b0, data_abort}, {127'b0, err && dp});
    check("R9/R10 xfer_done", {127'b0, ev_xfer_done}, {127'b0, xd});
    check("R10 stop", {127'b0, xfer_stop}, {127'b0, stp});
    check("R2 busy clear", {127'b0, cmd_busy}, 128'd0);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7321);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state
    check("R1 reset ready", {127'b0, cmd_ready}, 128'd1);
    check("R2 reset busy", {127'b0, cmd_busy}, 128'd0);
    check("R5 reset words", rsp_out, 128'd0);
    check("R8 reset err", {127'b0, card_err}, 128'd0);

    // R3 init shortcut, then index 2 still goes to the card
    init_mode = 1'b1;
    run_cmd(mk(0, 2, 1, 1), 32'h1, 4, rnd128(), 0, 0);
    run_cmd(mk(2, 1, 0, 0), 32'h2, 16, 128'h00112233_44556677_8899AABB_CCDDEEFF, 1, 2);
    init_mode = 1'b0;
    // R4 long too short, R5 long capture
    run_cmd(mk(9, 1, 0, 0), 32'h3, 15, rnd128(), 0, 0);
    run_cmd(mk(10, 1, 0, 0), 32'h4, 16, rnd128(), 2, 1);
    // R7/R8 standard mask with data read -> abort; then cleared
    err_enable = 32'hFFFF_FFFF;
    run_cmd(mk(17, 2, 1, 1), 32'h5, 4, {32'h8000_0000, 96'h0}, 0, 0);
    run_cmd(mk(17, 2, 1, 0), 32'h6, 4, {32'h0000_0100, 96'h0}, 0, 0);
    // R7 bit 25 is not in the standard set
    run_cmd(mk(18, 2, 0, 0), 32'h7, 4, {32'h0200_0000, 96'h0}, 0, 0);
    // R7 index 3
    run_cmd(mk(3, 2, 0, 0), 32'h8, 4, {32'h0000_0400, 96'h0}, 0, 0);
    run_cmd(mk(3, 2, 0, 0), 32'h9, 4, {32'h8000_0000, 96'h0}, 0, 0);
    // R7 index 41 and index 8
    run_cmd(mk(41, 2, 0, 0), 32'hA, 4, {32'hFFFF_FFFF, 96'h0}, 0, 0);
    card_is_mmc = 1'b0;
    run_cmd(mk(8, 2, 0, 0), 32'hB, 4, {32'hFFFF_FFFF, 96'h0}, 0, 0);
    card_is_mmc = 1'b1;
    run_cmd(mk(8, 2, 0, 0), 32'hC, 4, {32'hFFFF_FFFF, 96'h0}, 0, 0);
    // R8 enable mask gates the error
    err_enable = 32'h0;
    run_cmd(mk(17, 2, 0, 0), 32'hD, 4, {32'hFFFF_FFFF, 96'h0}, 0, 0);
    // R9 busy kind without and with data
    run_cmd(mk(7, 3, 0, 0), 32'hE, 4, rnd128(), 0, 0);
    run_cmd(mk(7, 3, 1, 0), 32'hF, 4, rnd128(), 0, 0);
    run_cmd(mk(7, 3, 0, 0), 32'h10, 3, rnd128(), 0, 0);
    // R10 stop commands
    run_cmd(mk(12, 3, 0, 0), 32'h11, 4, rnd128(), 0, 0);
    run_cmd(mk(52, 0, 0, 0), 32'h12, 0, rnd128(), 0, 0);
    // R4 kind none with zero length
    run_cmd(mk(5, 0, 1, 1), 32'h13, 0, rnd128(), 0, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int idx, kind, len, sel;
      logic [127:0] d;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0: idx = 3; 1: idx = 8; 2: idx = 12; 3: idx = 41;
        4: idx = 52; 5: idx = 0;
        default: idx = int'($urandom_range(0, 63));
      endcase
      kind = int'($urandom_range(0, 3));
      case ($urandom_range(0, 4))
        0: len = 0; 1: len = 3; 2: len = 4; 3: len = 15;
        default: len = 16;
      endcase
      init_mode   = ($urandom_range(0, 7) == 0);
      card_is_mmc = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 2))
        0: err_enable = 32'h0;
        1: err_enable = 32'hFFFF_FFFF;
        default: err_enable = $urandom;
      endcase
      d = rnd128();
      if ($urandom_range(0, 1) == 1) d[127:96] = 32'h0;
      run_cmd(mk(idx, kind, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1),
              $urandom, len, d, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule